// File: doc/BRIEF.md
# Digit-Serial Barrett Modular Multiplier

This block computes Z = X·Y mod M for an N-bit modulus whose top bit is set. It walks through the multiplier Y one W-bit digit at a time, starting with the most significant digit. In each step it shifts the running remainder left by one digit, adds X times the current digit, and then removes an estimated multiple of M.

The quotient estimate comes from the top bits of the running value and a reciprocal `mu`. The caller supplies `mu`, precomputed as floor(2^(N+W+3)/M). The estimate is made with shifts and one short multiplication. It is never more than one below the true quotient, so the remainder stays below 2M between steps. One conditional subtraction after the last digit brings the result into [0, M).

The caller presents X, Y, M and `mu` as parallel words together with a one-cycle `start`. The caller then waits for `done`. The result appears on `z_out`.

Top module: `modmul_barrett`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are 0 and `z_out` is 0.
- R2: For 2^(N-1) <= M < 2^N, 0 <= X, Y < M and mu = floor(2^(N+W+3)/M), the result on `z_out` equals X·Y mod M.
- R3: `start` is sampled only when the block is idle. `done` rises after the NW+1-th rising edge following the edge that sampled `start`, where NW = ceil(N/W). `busy` is 1 from the edge after `start` until `done` rises.
- R4: `done` is high for exactly one cycle, and `busy` is 0 whenever `done` is 1.
- R5: `z_out` changes only in the cycle in which `done` rises. It keeps its value until the next result, whatever the inputs do.
- R6: A `start` asserted while `busy` is 1 is ignored, along with any operand change at that time. The running operation ends at its normal time with the result for the operands captured at its own start.
- R7: Between digit steps the intermediate remainder stays below 2M, so that a single final subtraction is enough.
- R8: The result on `z_out` is always below M, including for the extreme operands 0 and M-1 and for the moduli 2^(N-1) and 2^N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| x_in | input | N | Multiplicand X |
| y_in | input | N | Multiplier Y, consumed top digit first |
| m_in | input | N | Modulus M, top bit set |
| mu_in | input | W+5 | Reciprocal floor(2^(N+W+3)/M) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when z_out is updated |
| z_out | output | N | Result X·Y mod M |

## Verification
The bench aims at the operands where the quotient estimate runs closest to its error bound: X = Y = M-1 with the smallest modulus 2^(N-1) and with the largest modulus 2^N-1. A design whose estimate erred by two would return a value of M or above there. The bench also checks the zero operands. A design that left the final correction out, or applied it twice, would return M or wrap below zero on them. In the middle of a run the bench asserts `start` with different operands. A design that reloaded its registers would report the wrong product, or would finish late.

// File: rtl/modmul_barrett.sv
module modmul_barrett #(
  parameter int N = 128,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  input  logic [N-1:0] m_in,
  input  logic [W+4:0] mu_in,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] z_out
);
  localparam int NW  = (N + W - 1) / W;
  localparam int YW  = NW * W;
  localparam int ZW  = N + W + 3;
  localparam int MUW = W + 5;
  localparam int TW  = ZW - (N - 2);
  localparam int PW  = TW + MUW;
  localparam int CW  = (NW > 1) ? $clog2(NW) : 1;

  typedef enum logic [1:0] {IDLE, RUN, FIX} state_t;

  state_t         state;
  logic [N-1:0]   x_q, m_q;
  logic [MUW-1:0] mu_q;
  logic [YW-1:0]  y_sh;
  logic [ZW-1:0]  z_q;
  logic [CW-1:0]  cnt;

  logic [W-1:0]   digit;
  logic [ZW-1:0]  z_acc, qm, z_next;
  logic [TW-1:0]  z_top;
  logic [PW-1:0]  prod;
  logic [ZW-1:0]  q_est;
  logic           ge_m;

  assign digit  = y_sh[YW-1 -: W];
  assign z_acc  = (z_q << W) + ZW'(x_q) * ZW'(digit);
  assign z_top  = z_acc[ZW-1:N-2];
  assign prod   = PW'(z_top) * PW'(mu_q);
  assign q_est  = ZW'(prod >> (W + 5));
  assign qm     = q_est * ZW'(m_q);
  assign z_next = z_acc - qm;
  assign ge_m   = z_q >= ZW'(m_q);
  assign busy   = (state != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE;
      x_q   <= '0;
      m_q   <= '0;
      mu_q  <= '0;
      y_sh  <= '0;
      z_q   <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      z_out <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          x_q   <= x_in;
          m_q   <= m_in;
          mu_q  <= mu_in;
          y_sh  <= YW'(y_in);
          z_q   <= '0;
          cnt   <= CW'(NW - 1);
          state <= RUN;
        end
        RUN: begin
          z_q  <= z_next;
          y_sh <= y_sh << W;
          cnt  <= cnt - 1'b1;
          if (cnt == '0) state <= FIX;
        end
        FIX: begin
          z_out <= ge_m ? N'(z_q - ZW'(m_q)) : N'(z_q);
          done  <= 1'b1;
          state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/modmul_barrett_chk.sv
module modmul_barrett_chk #(
  parameter int N = 128,
  parameter int W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [N-1:0]     z_out,
  input logic [N-1:0]     m_q,
  input logic [N+W+2:0]   z_q
);
  localparam int ZW = N + W + 3;

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_hold_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(z_out));

  assert_ignore_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(m_q));

  assert_rem_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (z_q < ZW'({m_q, 1'b0})));

  assert_result_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (z_out < m_q));
endmodule

bind modmul_barrett modmul_barrett_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .z_out(z_out), .m_q(m_q), .z_q(z_q)
);

// File: tb/modmul_barrett_bench.sv
module modmul_barrett_bench;
  localparam int N  = 128;
  localparam int W  = 16;
  localparam int NW = (N + W - 1) / W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] x_in = '0, y_in = '0, m_in = '0;
  logic [W+4:0] mu_in = '0;
  logic         busy, done;
  logic [N-1:0] z_out;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  modmul_barrett #(.N(N), .W(W)) u_modmul_barrett (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
    .m_in(m_in), .mu_in(mu_in), .busy(busy), .done(done), .z_out(z_out)
  );

  function automatic logic [N-1:0] gold(input logic [N-1:0] x, y, m);
    logic [2*N-1:0] p;
    p = (2*N)'(x) * (2*N)'(y);
    return N'(p % (2*N)'(m));
  endfunction

  function automatic logic [W+4:0] calc_mu(input logic [N-1:0] m);
    logic [N+W+3:0] num;
    num = '0;
    num[N+W+3] = 1'b1;
    return (W+5)'(num / (N+W+4)'(m));
  endfunction

  function automatic logic [N-1:0] rnd_word();
    logic [N-1:0] v;
    for (int k = 0; k < N; k += 32) v = (v << 32) | N'($urandom);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [N-1:0] act, exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic run_op(input logic [N-1:0] x, y, m, input bit inject);
    int edges;
    bool_t: begin end
    @(negedge clk);
    x_in = x; y_in = y; m_in = m; mu_in = calc_mu(m);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    edges = 0;
    while (!done && edges < 100) begin
      @(posedge clk); #1;
      edges++;
      if (!done) check(busy, "R3 busy during run", N'(busy), N'(1));
      if (inject && edges == 3) begin
        x_in = ~x; y_in = m - 1; start = 1'b1;
      end
      if (inject && edges == 4) start = 1'b0;
    end
    check(done, "R3 done seen", N'(done), N'(1));
    check(edges == NW + 1, inject ? "R6 latency with ignored start" : "R3 latency",
          N'(edges), N'(NW + 1));
    check(z_out == gold(x, y, m), inject ? "R6 result of first operands" : "R2 product",
          z_out, gold(x, y, m));
    check(z_out < m, "R8 result below modulus", z_out, m);
    check(!busy, "R4 busy low with done", N'(busy), N'(0));
    @(posedge clk); #1;
    check(!done, "R4 done single cycle", N'(done), N'(0));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] m, held;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !done && z_out == '0, "R1 reset state", z_out, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(!busy && !done && z_out == '0, "R1 after release", z_out, '0);

    m = {1'b1, {(N-1){1'b0}}};
    run_op(m - 1, m - 1, m, 1'b0);
    run_op('0, m - 1, m, 1'b0);
    m = '1;
    run_op(m - 1, m - 1, m, 1'b0);
    run_op(m - 1, '0, m, 1'b0);
    run_op(N'(1), m - 1, m, 1'b0);

    held = z_out;
    @(negedge clk); x_in = ~x_in; y_in = ~y_in; m_in = ~m_in;
    repeat (4) @(posedge clk);
    #1;
    check(z_out == held, "R5 result held", z_out, held);

    m = rnd_word() | {1'b1, {(N-1){1'b0}}};
    run_op(rnd_word() % m, rnd_word() % m, m, 1'b1);

    for (int t = 0; t < 40; t++) begin
      logic [N-1:0] rm;
      rm = rnd_word() | {1'b1, {(N-1){1'b0}}};
      run_op(rnd_word() % rm, rnd_word() % rm, rm, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule